// File: doc/BRIEF.md
# Ring-Linked Depth Expansion Controller

This block joins several equal FIFO stages into one deeper queue. Each stage keeps two ownership flags. The write token marks the one stage that accepts incoming words. The read token marks the one stage that supplies outgoing words. The stages form a closed ring, and each stage drives a handoff pulse into the next one. When the owning stage fills its final physical slot, it passes the write token along the ring. When it drains its final physical slot, it passes the read token along the ring. A one-bit qualifier sent with each pulse tells the receiving stage which of the two tokens is arriving.

Reset chooses the starting stage. The stage whose first-load pin is held low during reset begins with both tokens, and every other stage begins with neither. The wrapper builds the ring and routes the shared write and read strobes to every stage. Each stage works out its own enables from the tokens it holds and from its own occupancy. The wrapper also combines the per-stage active-low full and empty flags into composite flags. The storage arrays are outside this block. The block exports a write enable, a read enable, an output enable and a local slot address for each stage, which drive those arrays.

Top module: `fifo_depth_ring`

## Requirements
- R1: While reset is low, the stage whose `first_load_n` bit is 0 takes both tokens and every other stage takes none. All occupancy is cleared. After reset, `empty_n` is 0, `full_n` is 1 and every `oe` bit is 0.
- R2: In every cycle after reset, exactly one stage holds the write token and exactly one stage holds the read token.
- R3: `wr_en[s]` is 1 only when stage s holds the write token, `wr_req` is 1 and stage s is not full. The write addresses of a stage run 0, 1, … LOC_DEPTH-1 and then wrap to 0.
- R4: A write to local slot LOC_DEPTH-1 drives `xo_n` of that stage low for that cycle with `xo_rd`=0. From the next cycle, stage s+1 holds the write token, and after the last stage this wraps to stage 0.
- R5: A read from local slot LOC_DEPTH-1 drives `xo_n` of that stage low for that cycle with `xo_rd`=1. From the next cycle, stage s+1 holds the read token.
- R6: A write handoff and a read handoff that two different stages raise in the same cycle both take effect.
- R7: `full_n` is the OR of the per-stage full_n flags. It is 0 exactly when NUM_STAGES*LOC_DEPTH words are stored. While it is 0, writes raise no `wr_en` and change nothing.
- R8: `empty_n` is the OR of the per-stage empty_n flags. It is 0 exactly when no word is stored. While it is 0, reads raise no `rd_en` and change nothing.
- R9: `oe[s]` is 1 only when stage s holds the read token and stores at least one word.
- R10: Words written across stage boundaries are read back in the order they were written.
- R11: `rd_en[s]` is 1 only when stage s holds the read token, `rd_req` is 1 and stage s stores a word. Read addresses step from 0 to LOC_DEPTH-1 and then wrap.
- R12: When a write and a read are both accepted in the same cycle, the stored word count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; first-load pins are sampled while it is low |
| first_load_n | input | NUM_STAGES | Active-low first-load pin for each stage; exactly one bit is 0 |
| wr_req | input | 1 | Shared write strobe |
| rd_req | input | 1 | Shared read strobe |
| wr_en | output | NUM_STAGES | Per-stage write enable for its storage array |
| rd_en | output | NUM_STAGES | Per-stage read enable |
| oe | output | NUM_STAGES | Per-stage data output enable |
| waddr | output | NUM_STAGES*AW | Local write slot of each stage, AW bits per stage |
| raddr | output | NUM_STAGES*AW | Local read slot of each stage |
| xo_n | output | NUM_STAGES | Active-low handoff pulse out of each stage |
| xo_rd | output | NUM_STAGES | Handoff qualifier: 1 means read token, 0 means write token |
| full_n | output | 1 | Composite active-low full flag |
| empty_n | output | 1 | Composite active-low empty flag |

## Verification
The first pattern is a full fill followed by surplus writes, and then a full drain followed by surplus reads. This shows whether the handoff ring and the composite flags stop at the true boundaries rather than at one stage's boundary. The second pattern holds the queue at exactly one stage's worth of words and then streams writes and reads together. This makes different stages raise write and read handoffs in the same cycle, which shows whether both tokens move. The third pattern is a long mix of writes and reads under two different first-load stages. It shows whether the starting owner, the wrap from the last stage to the first, and data order across stage boundaries all hold.

// File: rtl/fce_pkg.sv
package fce_pkg;
    typedef enum logic {
        HAND_WR = 1'b0,
        HAND_RD = 1'b1
    } hand_kind_e;
endpackage

// File: rtl/fce_stage.sv
module fce_stage
    import fce_pkg::*;
#(
    parameter int LOC_DEPTH = 4,
    parameter int AW        = (LOC_DEPTH > 1) ? $clog2(LOC_DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          first_load_n,
    input  logic          xi_n,
    input  logic          xi_rd,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_en,
    output logic          rd_en,
    output logic          oe,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          xo_n,
    output logic          xo_rd,
    output logic          full_n,
    output logic          empty_n,
    output logic          has_wtok,
    output logic          has_rtok
);
    localparam int              CW    = $clog2(LOC_DEPTH + 1);
    localparam logic [AW-1:0]   LAST  = AW'(LOC_DEPTH - 1);
    localparam logic [CW-1:0]   FULLV = CW'(LOC_DEPTH);

    typedef struct packed {
        logic          wtok;
        logic          rtok;
        logic [AW-1:0] wa;
        logic [AW-1:0] ra;
        logic [CW-1:0] cnt;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic      w_last, r_last, w_in, r_in;

    always_comb begin
        wr_en  = st_q.wtok & wr_req & (st_q.cnt != FULLV);
        rd_en  = st_q.rtok & rd_req & (st_q.cnt != '0);
        w_last = wr_en & (st_q.wa == LAST);
        r_last = rd_en & (st_q.ra == LAST);
        w_in   = ~xi_n & (xi_rd == HAND_WR);
        r_in   = ~xi_n & (xi_rd == HAND_RD);

        st_d      = st_q;
        st_d.wtok = (st_q.wtok & ~w_last) | w_in;
        st_d.rtok = (st_q.rtok & ~r_last) | r_in;
        if (wr_en) st_d.wa = w_last ? '0 : st_q.wa + 1'b1;
        if (rd_en) st_d.ra = r_last ? '0 : st_q.ra + 1'b1;
        st_d.cnt = st_q.cnt + CW'(wr_en) - CW'(rd_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wtok <= ~first_load_n;
            st_q.rtok <= ~first_load_n;
            st_q.wa   <= '0;
            st_q.ra   <= '0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xo_n     = ~(w_last | r_last);
    assign xo_rd    = r_last;
    assign oe       = st_q.rtok & (st_q.cnt != '0);
    assign waddr    = st_q.wa;
    assign raddr    = st_q.ra;
    assign full_n   = (st_q.cnt != FULLV);
    assign empty_n  = (st_q.cnt != '0);
    assign has_wtok = st_q.wtok;
    assign has_rtok = st_q.rtok;

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULLV);
    assert_wr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xo_n && !xo_rd) |=> (st_q.wa == '0));
    assert_rd_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!xo_n && xo_rd) |=> (st_q.ra == '0));
    assert_rd_token_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!xi_n && xi_rd) |=> st_q.rtok);
endmodule

// File: rtl/fifo_depth_ring.sv
module fifo_depth_ring #(
    parameter int NUM_STAGES = 4,
    parameter int LOC_DEPTH  = 4,
    parameter int AW         = (LOC_DEPTH > 1) ? $clog2(LOC_DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_STAGES-1:0]    first_load_n,
    input  logic                     wr_req,
    input  logic                     rd_req,
    output logic [NUM_STAGES-1:0]    wr_en,
    output logic [NUM_STAGES-1:0]    rd_en,
    output logic [NUM_STAGES-1:0]    oe,
    output logic [NUM_STAGES*AW-1:0] waddr,
    output logic [NUM_STAGES*AW-1:0] raddr,
    output logic [NUM_STAGES-1:0]    xo_n,
    output logic [NUM_STAGES-1:0]    xo_rd,
    output logic                     full_n,
    output logic                     empty_n
);
    logic [NUM_STAGES-1:0] st_full_n, st_empty_n, wtok_v, rtok_v;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        localparam int PRV = (s + NUM_STAGES - 1) % NUM_STAGES;
        localparam int NXT = (s + 1) % NUM_STAGES;

        fce_stage #(.LOC_DEPTH(LOC_DEPTH), .AW(AW)) stage_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .first_load_n(first_load_n[s]),
            .xi_n        (xo_n[PRV]),
            .xi_rd       (xo_rd[PRV]),
            .wr_req      (wr_req),
            .rd_req      (rd_req),
            .wr_en       (wr_en[s]),
            .rd_en       (rd_en[s]),
            .oe          (oe[s]),
            .waddr       (waddr[s*AW +: AW]),
            .raddr       (raddr[s*AW +: AW]),
            .xo_n        (xo_n[s]),
            .xo_rd       (xo_rd[s]),
            .full_n      (st_full_n[s]),
            .empty_n     (st_empty_n[s]),
            .has_wtok    (wtok_v[s]),
            .has_rtok    (rtok_v[s])
        );

        assert_wr_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!xo_n[s] && !xo_rd[s]) |=> wtok_v[NXT]);
        assert_rd_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!xo_n[s] && xo_rd[s]) |=> rtok_v[NXT]);
    end

    assign full_n  = |st_full_n;
    assign empty_n = |st_empty_n;

    assert_one_writer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wtok_v) == 1);
    assert_one_reader_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rtok_v) == 1);
    assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (wr_en == '0));
    assert_no_read_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> (rd_en == '0));
    assert_single_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en) && $onehot0(rd_en));
endmodule

// File: tb/fifo_depth_ring_tb_top.sv
`timescale 1ns/1ps
module fifo_depth_ring_tb_top;
    localparam int N  = 4;
    localparam int D  = 4;
    localparam int AW = 2;
    localparam int ND = N * D;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    first_load_n = '1;
    logic            wr_req = 1'b0, rd_req = 1'b0;
    logic [N-1:0]    wr_en, rd_en, oe, xo_n, xo_rd;
    logic [N*AW-1:0] waddr, raddr;
    logic            full_n, empty_n;

    int checks = 0, fails = 0;
    int wc = 0, rc = 0, fl = 0, next_word = 1;
    int mem [N][D];
    int q[$];

    always #2.5 clk = ~clk;

    fifo_depth_ring #(.NUM_STAGES(N), .LOC_DEPTH(D), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
        .wr_req(wr_req), .rd_req(rd_req), .wr_en(wr_en), .rd_en(rd_en),
        .oe(oe), .waddr(waddr), .raddr(raddr), .xo_n(xo_n), .xo_rd(xo_rd),
        .full_n(full_n), .empty_n(empty_n));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int first);
        @(negedge clk);
        rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
        first_load_n = ~(N'(1) << first);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fl = first; wc = 0; rc = 0; q.delete();
        #1;
        chk(oe == '0, "R1 oe", int'(oe), 0);
        chk(full_n == 1'b1, "R1 full_n", int'(full_n), 1);
        chk(empty_n == 1'b0, "R1 empty_n", int'(empty_n), 0);
    endtask

    task automatic step(input bit w, input bit r);
        int ws, wa, rs, ra, occ;
        bit ew, er;
        logic [N-1:0] e_wr, e_rd, e_oe, e_xo, e_xr;
        @(negedge clk);
        wr_req = w; rd_req = r;
        #1;
        ws = (fl + wc / D) % N; wa = wc % D;
        rs = (fl + rc / D) % N; ra = rc % D;
        occ = wc - rc;
        ew = w && (occ < ND);
        er = r && (occ > 0);
        e_wr = '0; e_rd = '0; e_oe = '0; e_xo = '1; e_xr = '0;
        if (ew) e_wr[ws] = 1'b1;
        if (er) e_rd[rs] = 1'b1;
        if (occ > 0) e_oe[rs] = 1'b1;
        if (ew && wa == D - 1) e_xo[ws] = 1'b0;
        if (er && ra == D - 1) begin e_xo[rs] = 1'b0; e_xr[rs] = 1'b1; end
        chk(wr_en == e_wr, "R3 wr_en (R2 single writer)", int'(wr_en), int'(e_wr));
        chk(rd_en == e_rd, "R11 rd_en (R2 single reader)", int'(rd_en), int'(e_rd));
        chk(oe == e_oe, "R9 oe", int'(oe), int'(e_oe));
        chk(xo_n == e_xo, "R4/R5 xo_n (R6 concurrent)", int'(xo_n), int'(e_xo));
        chk((xo_rd & ~xo_n) == e_xr, "R5 xo_rd", int'(xo_rd & ~xo_n), int'(e_xr));
        chk(full_n == (occ != ND), "R7 full_n", int'(full_n), int'(occ != ND));
        chk(empty_n == (occ != 0), "R8 empty_n", int'(empty_n), int'(occ != 0));
        if (ew) chk(int'(waddr[ws*AW +: AW]) == wa, "R3 waddr", int'(waddr[ws*AW +: AW]), wa);
        if (er) chk(int'(raddr[rs*AW +: AW]) == ra, "R11 raddr", int'(raddr[rs*AW +: AW]), ra);
        if (er) begin
            int got, want;
            got = mem[rs][ra];
            want = q.pop_front();
            chk(got == want, "R10 order", got, want);
            rc++;
        end
        if (ew) begin
            mem[ws][wa] = next_word;
            q.push_back(next_word);
            next_word++;
            wc++;
        end
        if (ew && er) chk(wc - rc == occ, "R12 occupancy", wc - rc, occ);
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset(0);
        for (int i = 0; i < ND + 3; i++) step(1'b1, 1'b0);   // R7 fill and surplus writes
        step(1'b1, 1'b0);
        for (int i = 0; i < ND + 3; i++) step(1'b0, 1'b1);   // R8 drain and surplus reads
        for (int i = 0; i < D; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 24; i++) step(1'b1, 1'b1);       // R6 same-cycle handoffs
        for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        do_reset(2);                                         // R1 different first-load stage
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)));
        for (int i = 0; i < ND + 2; i++) step(1'b0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule